// File: doc/BRIEF.md
# Indirect Address Pointer Unit

This block keeps three 12-bit data-memory pointers and turns them into the address for indirect reads and writes. A 2-bit select picks one pointer per cycle. The access mode code then decides two things: which address goes to the data RAM, and how the pointer moves afterwards. The pointer can stay put, step up after the access, step down after the access, or step up before the access. Every step is taken modulo 4096 across all 12 bits. Stepping never touches any status flag, and the block has no flag outputs.

Software can change a pointer in two ways. A load strobe writes a full 12-bit value, and the new value takes effect two cycles later. Byte writes replace either the low eight bits or the upper four bits of the selected pointer. A low-byte write does not carry into the upper bits. Both halves of the selected pointer can be read back on byte-wide outputs.

Top module: `ind_ptr_unit`

## Requirements
- R1: After reset, all three pointers read 0x000, `ld_busy` is 0 and no load is pending.
- R2: A `ld_strobe` with `ptr_sel` in 0..2 sets `ld_busy` for exactly the next cycle. The second clock edge writes `ld_value` into that pointer. A strobe is ignored while `ld_busy` is 1 or when `ptr_sel` is 3.
- R3: Mode 1 (plain access) drives `ram_en`=1 and `ram_addr` equal to the selected pointer in the same cycle. The pointer does not change.
- R4: Mode 2 (post-increment) puts the current pointer on `ram_addr`. The pointer then becomes pointer+1 modulo 4096, carrying into the upper bits: 0x0FF becomes 0x100 and 0xFFF becomes 0x000.
- R5: Mode 3 (post-decrement) puts the current pointer on `ram_addr`. The pointer then becomes pointer-1 modulo 4096, borrowing from the upper bits: 0x100 becomes 0x0FF and 0x000 becomes 0xFFF.
- R6: Mode 4 (pre-increment) puts pointer+1 modulo 4096 on `ram_addr`, and the pointer stores that same value.
- R7: `wr_lo` replaces bits 7..0 of the selected pointer with `wr_byte` and leaves bits 11..8 alone. Writing 0x00 to the low byte of 0x0FF gives 0x000.
- R8: `wr_hi` stores `wr_byte[3:0]` into bits 11..8 of the selected pointer. `rd_hi` always returns zeros in bits 7..4.
- R9: `rd_lo` and `rd_hi` show the low and high halves of the selected pointer. With `ptr_sel`=3 the read outputs are 0, `ram_en` is 0, and no pointer changes.
- R10: For a single pointer, a load commit beats a byte write, and a byte write beats a mode step. While a byte write is active the address is still driven, but the step is dropped.
- R11: An operation changes only the pointer it targets. The other two pointers keep their values.
- R12: Mode 0 and modes 5..7 drive `ram_en`=0 and leave the pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_sel | input | 2 | Pointer select: 0..2 are pointers, 3 selects none |
| acc_mode | input | 3 | Access mode: 0 idle, 1 plain, 2 post-inc, 3 post-dec, 4 pre-inc |
| wr_lo | input | 1 | Write `wr_byte` into the low byte of the selected pointer |
| wr_hi | input | 1 | Write `wr_byte[3:0]` into the upper bits of the selected pointer |
| wr_byte | input | 8 | Data for byte writes |
| ld_strobe | input | 1 | Start a two-cycle full-pointer load |
| ld_value | input | 12 | Value for the load |
| ram_addr | output | 12 | Effective data RAM address |
| ram_en | output | 1 | An indirect access happens this cycle |
| rd_lo | output | 8 | Low byte of the selected pointer |
| rd_hi | output | 8 | Upper bits of the selected pointer, zero-extended |
| ld_busy | output | 1 | A load is waiting to commit |

## Verification
The step assertions assume that a cycle's load commit, byte write and mode step may all aim at the same pointer. Each assertion therefore checks a step only when no higher-priority write is active on that pointer. The stimulus deliberately creates those collisions in a directed case, so the priority order is exercised rather than avoided. The random phase then drives every select value, including 3, and every mode code, including the unused ones. It also fires load strobes while a load is pending, so the conditions the assertions filter out really do occur.

// File: rtl/ind_ptr_pkg.sv
package ind_ptr_pkg;

    typedef enum logic [2:0] {
        MODE_IDLE    = 3'd0,
        MODE_PLAIN   = 3'd1,
        MODE_POSTINC = 3'd2,
        MODE_POSTDEC = 3'd3,
        MODE_PREINC  = 3'd4
    } acc_mode_e;

endpackage

// File: rtl/ind_ptr_slot.sv
module ind_ptr_slot #(
    parameter int PTR_W  = 12,
    parameter int BYTE_W = 8,
    localparam int HI_W  = PTR_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_en,
    input  logic [PTR_W-1:0]  commit_val,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] byte_lo,
    input  logic [HI_W-1:0]   byte_hi,
    input  logic              step_up,
    input  logic              step_dn,
    output logic [PTR_W-1:0]  ptr_q
);

    logic [PTR_W-1:0] ptr_d;

    // Priority: load commit, then byte writes, then mode step.
    always_comb begin
        ptr_d = ptr_q;
        if (commit_en) begin
            ptr_d = commit_val;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) ptr_d[BYTE_W-1:0]     = byte_lo;
            if (wr_hi) ptr_d[PTR_W-1:BYTE_W] = byte_hi;
        end else if (step_up) begin
            ptr_d = ptr_q + PTR_W'(1);
        end else if (step_dn) begin
            ptr_d = ptr_q - PTR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    a_r4_step_up_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && !commit_en && !wr_lo && !wr_hi) |=> ptr_q == PTR_W'($past(ptr_q) + PTR_W'(1)));

    a_r5_step_dn_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (step_dn && !step_up && !commit_en && !wr_lo && !wr_hi) |=> ptr_q == PTR_W'($past(ptr_q) - PTR_W'(1)));

    a_r10_commit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> ptr_q == $past(commit_val));

    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_en && !wr_lo && !wr_hi && !step_up && !step_dn) |=> $stable(ptr_q));

    a_r7_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi && !commit_en) |=> ptr_q[PTR_W-1:BYTE_W] == $past(ptr_q[PTR_W-1:BYTE_W]));

endmodule

// File: rtl/ind_ptr_load_stage.sv
module ind_ptr_load_stage #(
    parameter int NUM_PTR = 3,
    parameter int PTR_W   = 12,
    localparam int SEL_W  = $clog2(NUM_PTR + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe,
    input  logic [SEL_W-1:0]   sel,
    input  logic [PTR_W-1:0]   value,
    output logic               busy,
    output logic [NUM_PTR-1:0] commit_en,
    output logic [PTR_W-1:0]   commit_val
);

    typedef struct packed {
        logic             busy;
        logic [SEL_W-1:0] tgt;
        logic [PTR_W-1:0] val;
    } stage_t;

    stage_t st_d, st_q;
    logic   sel_ok;

    assign sel_ok = (sel < SEL_W'(NUM_PTR));

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.busy = 1'b0;
        end else if (strobe && sel_ok) begin
            st_d.busy = 1'b1;
            st_d.tgt  = sel;
            st_d.val  = value;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar k = 0; k < NUM_PTR; k++) begin : g_commit
        assign commit_en[k] = st_q.busy && (st_q.tgt == SEL_W'(k));
    end

    assign busy       = st_q.busy;
    assign commit_val = st_q.val;

    a_r2_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    a_r2_strobe_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && sel_ok && !busy) |=> (busy && commit_val == $past(value)));

    a_r2_commit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(commit_en));

endmodule

// File: rtl/ind_ptr_addr_gen.sv
module ind_ptr_addr_gen
    import ind_ptr_pkg::*;
#(
    parameter int PTR_W = 12
) (
    input  logic [PTR_W-1:0] ptr_cur,
    input  logic [2:0]       mode,
    input  logic             sel_ok,
    output logic [PTR_W-1:0] ram_addr,
    output logic             ram_en,
    output logic             step_up,
    output logic             step_dn
);

    always_comb begin
        ram_addr = ptr_cur;
        ram_en   = 1'b0;
        step_up  = 1'b0;
        step_dn  = 1'b0;
        if (sel_ok) begin
            case (mode)
                MODE_PLAIN: begin
                    ram_en = 1'b1;
                end
                MODE_POSTINC: begin
                    ram_en  = 1'b1;
                    step_up = 1'b1;
                end
                MODE_POSTDEC: begin
                    ram_en  = 1'b1;
                    step_dn = 1'b1;
                end
                MODE_PREINC: begin
                    ram_en   = 1'b1;
                    step_up  = 1'b1;
                    ram_addr = ptr_cur + PTR_W'(1);
                end
                default: begin
                    ram_en = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/ind_ptr_unit.sv
module ind_ptr_unit
    import ind_ptr_pkg::*;
#(
    parameter int NUM_PTR = 3,
    parameter int PTR_W   = 12,
    parameter int BYTE_W  = 8,
    localparam int SEL_W  = $clog2(NUM_PTR + 1),
    localparam int HI_W   = PTR_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  ptr_sel,
    input  logic [2:0]        acc_mode,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              ld_strobe,
    input  logic [PTR_W-1:0]  ld_value,
    output logic [PTR_W-1:0]  ram_addr,
    output logic              ram_en,
    output logic [BYTE_W-1:0] rd_lo,
    output logic [BYTE_W-1:0] rd_hi,
    output logic              ld_busy
);

    logic [PTR_W-1:0]   ptr_q [NUM_PTR];
    logic [PTR_W-1:0]   ptr_cur;
    logic               sel_ok;
    logic               step_up, step_dn;
    logic [NUM_PTR-1:0] commit_en;
    logic [PTR_W-1:0]   commit_val;

    assign sel_ok = (ptr_sel < SEL_W'(NUM_PTR));

    always_comb begin
        ptr_cur = '0;
        for (int k = 0; k < NUM_PTR; k++) begin
            if (ptr_sel == SEL_W'(k)) ptr_cur = ptr_q[k];
        end
    end

    ind_ptr_load_stage #(.NUM_PTR(NUM_PTR), .PTR_W(PTR_W)) u_load (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (ld_strobe),
        .sel        (ptr_sel),
        .value      (ld_value),
        .busy       (ld_busy),
        .commit_en  (commit_en),
        .commit_val (commit_val)
    );

    ind_ptr_addr_gen #(.PTR_W(PTR_W)) u_addr (
        .ptr_cur  (ptr_cur),
        .mode     (acc_mode),
        .sel_ok   (sel_ok),
        .ram_addr (ram_addr),
        .ram_en   (ram_en),
        .step_up  (step_up),
        .step_dn  (step_dn)
    );

    for (genvar k = 0; k < NUM_PTR; k++) begin : g_slot
        logic hit;
        assign hit = sel_ok && (ptr_sel == SEL_W'(k));

        ind_ptr_slot #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .commit_en  (commit_en[k]),
            .commit_val (commit_val),
            .wr_lo      (wr_lo && hit),
            .wr_hi      (wr_hi && hit),
            .byte_lo    (wr_byte),
            .byte_hi    (wr_byte[HI_W-1:0]),
            .step_up    (step_up && hit),
            .step_dn    (step_dn && hit),
            .ptr_q      (ptr_q[k])
        );
    end

    assign rd_lo = ptr_cur[BYTE_W-1:0];
    assign rd_hi = {{(BYTE_W-HI_W){1'b0}}, ptr_cur[PTR_W-1:BYTE_W]};

    a_r9_no_access_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_ok |-> (!ram_en && rd_lo == '0 && rd_hi == '0));

    a_r3_plain_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && acc_mode == MODE_PLAIN) |-> ram_addr == {rd_hi[HI_W-1:0], rd_lo});

    a_r6_preinc_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && acc_mode == MODE_PREINC && !wr_lo && !wr_hi && !(|commit_en))
        |=> {rd_hi[HI_W-1:0], rd_lo} == $past(ram_addr) || $past(ptr_sel) != ptr_sel);

    a_r12_unused_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mode == MODE_IDLE || acc_mode > MODE_PREINC) |-> !ram_en);

endmodule

// File: tb/ind_ptr_unit_tb_top.sv
module ind_ptr_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ptr_sel = 2'd3;
    logic [2:0]  acc_mode = 3'd0;
    logic        wr_lo = 1'b0, wr_hi = 1'b0;
    logic [7:0]  wr_byte = 8'h00;
    logic        ld_strobe = 1'b0;
    logic [11:0] ld_value = 12'h000;
    logic [11:0] ram_addr;
    logic        ram_en;
    logic [7:0]  rd_lo, rd_hi;
    logic        ld_busy;

    int checks = 0;
    int fails  = 0;

    int m_ptr [3];
    int m_busy = 0;
    int m_tgt  = 0;
    int m_val  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ind_ptr_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_sel   (ptr_sel),
        .acc_mode  (acc_mode),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .wr_byte   (wr_byte),
        .ld_strobe (ld_strobe),
        .ld_value  (ld_value),
        .ram_addr  (ram_addr),
        .ram_en    (ram_en),
        .rd_lo     (rd_lo),
        .rd_hi     (rd_hi),
        .ld_busy   (ld_busy)
    );

    task automatic compare(input string tag);
        int s, md, p, e_addr, e_en, e_lo, e_hi;
        s  = ptr_sel;
        md = acc_mode;
        p  = (s < 3) ? m_ptr[s] : 0;
        e_en   = (s < 3 && md >= 1 && md <= 4) ? 1 : 0;
        e_addr = (s < 3 && md == 4) ? ((p + 1) % 4096) : p;
        e_lo   = p % 256;
        e_hi   = p / 256;
        checks++;
        if (ram_en !== e_en[0] || (e_en == 1 && ram_addr !== e_addr[11:0]) ||
            rd_lo !== e_lo[7:0] || rd_hi !== e_hi[7:0] || ld_busy !== m_busy[0]) begin
            fails++;
            $display("FAIL %s: actual en=%0d addr=%03h lo=%02h hi=%02h busy=%0d expected en=%0d addr=%03h lo=%02h hi=%02h busy=%0d",
                     tag, ram_en, ram_addr, rd_lo, rd_hi, ld_busy,
                     e_en, e_addr, e_lo, e_hi, m_busy);
        end
    endtask

    task automatic model_edge();
        int s, md, np [3];
        s  = ptr_sel;
        md = acc_mode;
        for (int k = 0; k < 3; k++) np[k] = m_ptr[k];
        if (s < 3) begin
            if (wr_lo || wr_hi) begin
                if (wr_lo) np[s] = (np[s] / 256) * 256 + wr_byte;
                if (wr_hi) np[s] = (np[s] % 256) + (wr_byte % 16) * 256;
            end else if (md == 2 || md == 4) begin
                np[s] = (np[s] + 1) % 4096;
            end else if (md == 3) begin
                np[s] = (np[s] + 4095) % 4096;
            end
        end
        if (m_busy == 1) begin
            np[m_tgt] = m_val;
            m_busy = 0;
        end else if (ld_strobe && s < 3) begin
            m_busy = 1;
            m_tgt  = s;
            m_val  = ld_value;
        end
        for (int k = 0; k < 3; k++) m_ptr[k] = np[k];
    endtask

    task automatic step(input int sel, input int mode, input bit lo, input bit hi,
                        input int data, input bit ld, input int ldv, input string tag);
        @(negedge clk);
        ptr_sel   = sel[1:0];
        acc_mode  = mode[2:0];
        wr_lo     = lo;
        wr_hi     = hi;
        wr_byte   = data[7:0];
        ld_strobe = ld;
        ld_value  = ldv[11:0];
        #1;
        compare(tag);
        @(posedge clk);
        model_edge();
    endtask

    task automatic load(input int sel, input int v);
        step(sel, 0, 0, 0, 0, 1, v, "R2");
        step(3, 0, 0, 0, 0, 0, 0, "R2");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 3; k++) m_ptr[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of each pointer
        step(0, 0, 0, 0, 0, 0, 0, "R1");
        step(1, 0, 0, 0, 0, 0, 0, "R1");
        step(2, 0, 0, 0, 0, 0, 0, "R1");

        // R2: load with busy window, strobe ignored while busy
        step(0, 0, 0, 0, 0, 1, 'h0FF, "R2");
        step(1, 0, 0, 0, 0, 1, 'h555, "R2");
        step(0, 1, 0, 0, 0, 0, 0, "R2");
        step(1, 1, 0, 0, 0, 0, 0, "R2");
        step(3, 0, 0, 0, 0, 1, 'h777, "R2");
        step(3, 0, 0, 0, 0, 0, 0, "R2");

        // R4: carry from low byte into upper bits
        step(0, 2, 0, 0, 0, 0, 0, "R4");
        step(0, 1, 0, 0, 0, 0, 0, "R4");
        // R5: borrow back
        step(0, 3, 0, 0, 0, 0, 0, "R5");
        step(0, 1, 0, 0, 0, 0, 0, "R5");
        // R5: 0x000 wraps to 0xFFF, R4: 0xFFF wraps to 0x000
        step(1, 3, 0, 0, 0, 0, 0, "R5");
        step(1, 2, 0, 0, 0, 0, 0, "R4");
        step(1, 1, 0, 0, 0, 0, 0, "R4");

        // R7: low byte write does not carry
        step(0, 0, 1, 0, 'h00, 0, 0, "R7");
        step(0, 1, 0, 0, 0, 0, 0, "R7");
        // R8: upper write keeps only 4 bits
        step(2, 0, 0, 1, 'hAB, 0, 0, "R8");
        step(2, 0, 1, 0, 'h34, 0, 0, "R8");
        step(2, 1, 0, 0, 0, 0, 0, "R8");

        // R6: pre-increment uses the new value
        step(2, 4, 0, 0, 0, 0, 0, "R6");
        step(2, 1, 0, 0, 0, 0, 0, "R6");
        load(2, 'hFFF);
        step(2, 4, 0, 0, 0, 0, 0, "R6");
        step(2, 1, 0, 0, 0, 0, 0, "R6");

        // R3: plain access holds pointer
        step(2, 1, 0, 0, 0, 0, 0, "R3");
        step(2, 1, 0, 0, 0, 0, 0, "R3");

        // R12: unused modes
        for (int md = 5; md < 8; md++) step(0, md, 0, 0, 0, 0, 0, "R12");
        step(0, 0, 0, 0, 0, 0, 0, "R12");

        // R9: select 3
        step(3, 2, 1, 1, 'hFF, 0, 0, "R9");
        step(0, 1, 0, 0, 0, 0, 0, "R9");

        // R10: byte write beats step; commit beats step and byte write
        step(0, 2, 1, 0, 'h42, 0, 0, "R10");
        step(0, 1, 0, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 1, 'h321, "R10");
        step(0, 2, 1, 1, 'h99, 0, 0, "R10");
        step(0, 1, 0, 0, 0, 0, 0, "R10");

        // R11: independence across pointers, random mix
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom;
            step(r % 4, (r / 4) % 8, ((r / 32) % 8) == 0, ((r / 256) % 8) == 0,
                 (r / 2048) % 256, ((r / 524288) % 6) == 0, (r / 8) % 4096, "R11");
        end
        for (int k = 0; k < 3; k++) step(k, 1, 0, 0, 0, 0, 0, "R11");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule